// File: doc/BRIEF.md
# MSI termination bank

This block terminates message-signalled interrupt writes arriving from PCIe root ports. It holds 2048 vector bits, arranged as 16 groups. Each group has 8 index registers, and each index register is 16 bits wide. A posted write carries an address and a data value. The address picks the group and the index register. The data value picks which bit to set.

The 2048 vectors fold onto 16 level interrupt outputs, one for each group. Each group also has a read-only summary register that shows which of its index registers hold pending bits.

An interrupt handler uses the outputs as follows:

1. On seeing a group line high, it reads that group's summary register.
2. It then reads each flagged index register. That read returns the pending bits and clears them in the same access.
3. It repeats until the line drops.

Top module: `msi_term_bank`

## Requirements
- R1: A write with `wr_valid` high, address (g << 19) + (x << 16) (group g in 0..15, index x in 0..7) and data d in 0..15 sets bit d of index register (g, x). The bit is readable from the next cycle.
- R2: A read (`rd_en` high) of an index register address returns that register's pending bits on `rd_data` in the cycle after `rd_en`, and leaves the register at zero.
- R3: A read of summary address 0x800000 + (g << 16) returns, in `rd_data` bit x, whether index register x of group g holds any pending bit. Bits 15:8 of `rd_data` are zero, and the read changes no state.
- R4: `irq_out[g]` is a level that is 1 exactly while some index register of group g holds a pending bit.
- R5: If a write sets a bit in the same cycle that a read clears the same index register, `rd_data` shows the contents from before that cycle. The newly set bit remains pending afterwards.
- R6: A write whose data value is 16 or more changes no state.
- R7: A write to an address outside the index register space changes no state. This covers an address with bit 23 set, and an address with any of bits 15:0 nonzero.
- R8: Reset (`rst_n` low) clears all pending bits. During reset `rd_data` and `irq_out` are zero.
- R9: A read of an address that is neither an index register nor a summary register returns zero and changes no state.
- R10: Writes accumulate by OR. Setting a bit that is already pending leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Posted interrupt write strobe |
| wr_addr | input | 24 | Byte offset of the write from the block base |
| wr_data | input | 32 | Write data: vector bit number |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 24 | Byte offset of the read |
| rd_data | output | 16 | Read result, valid the cycle after `rd_en` |
| irq_out | output | 16 | One level interrupt line per group |

## Verification
The bench hits a register with a write and a read in the same cycle. A design whose clear wins there would silently lose an interrupt. It writes data values of 16 and above, and addresses with bit 23 set or low bits nonzero. A decoder that truncates data or ignores those address bits would alias such a write onto a real vector. It reads summary registers repeatedly, where a summary read with side effects would drain pending state. It also reads unmapped addresses, which a loose decoder would let alias onto group registers. Group 15 index 7 and vector 15 are driven directly, so that an off-by-one in the address fields would set the wrong bit or the wrong line.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  localparam int NUM_GRP     = 16;
  localparam int IDX_PER_GRP = 8;
  localparam int VEC_PER_IDX = 16;
  localparam int DATA_W      = 32;
  localparam int IDX_SHIFT   = 16;
  localparam int GRP_W       = $clog2(NUM_GRP);
  localparam int IDX_W       = $clog2(IDX_PER_GRP);
  localparam int VEC_W       = $clog2(VEC_PER_IDX);
  localparam int GRP_SHIFT   = IDX_SHIFT + IDX_W;
  localparam int SUM_BIT     = GRP_SHIFT + GRP_W;
  localparam int ADDR_W      = SUM_BIT + 1;

  typedef struct packed {
    logic             hit;
    logic [GRP_W-1:0] grp;
    logic [IDX_W-1:0] idx;
  } reg_sel_t;

  // Index register space: top bit clear, byte offset low field zero.
  function automatic reg_sel_t decode_index(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    s.hit = (a[SUM_BIT] == 1'b0) && (a[IDX_SHIFT-1:0] == '0);
    s.grp = a[SUM_BIT-1:GRP_SHIFT];
    s.idx = a[GRP_SHIFT-1:IDX_SHIFT];
    return s;
  endfunction

  // Summary space: top bit set, group in the field just above the low offset.
  function automatic reg_sel_t decode_summary(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    s.hit = (a[SUM_BIT] == 1'b1) && (a[SUM_BIT-1:IDX_SHIFT+GRP_W] == '0)
            && (a[IDX_SHIFT-1:0] == '0);
    s.grp = a[IDX_SHIFT+GRP_W-1:IDX_SHIFT];
    s.idx = '0;
    return s;
  endfunction

  function automatic logic [VEC_PER_IDX-1:0] vec_onehot(input logic [DATA_W-1:0] d);
    logic [VEC_PER_IDX-1:0] v;
    v = '0;
    v[d[VEC_W-1:0]] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/msi_term_decode.sv
module msi_term_decode
  import msi_term_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic                   wr_hit,
  output logic [GRP_W-1:0]       wr_grp,
  output logic [IDX_W-1:0]       wr_idx,
  output logic [VEC_PER_IDX-1:0] wr_vec,
  output logic                   rd_idx_hit,
  output logic                   rd_sum_hit,
  output logic [GRP_W-1:0]       rd_grp,
  output logic [IDX_W-1:0]       rd_idx
);
  reg_sel_t wsel, rsel_i, rsel_s;
  logic     data_ok;

  always_comb begin
    wsel    = decode_index(wr_addr);
    rsel_i  = decode_index(rd_addr);
    rsel_s  = decode_summary(rd_addr);
    data_ok = (wr_data < DATA_W'(VEC_PER_IDX));
    wr_hit  = wr_valid && wsel.hit && data_ok;
    wr_grp  = wsel.grp;
    wr_idx  = wsel.idx;
    wr_vec  = vec_onehot(wr_data);
    rd_idx_hit = rd_en && rsel_i.hit;
    rd_sum_hit = rd_en && rsel_s.hit;
    rd_grp  = rsel_i.hit ? rsel_i.grp : rsel_s.grp;
    rd_idx  = rsel_i.idx;
  end

  p_data_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_data >= DATA_W'(VEC_PER_IDX))) |-> !wr_hit);
  p_addr_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr[SUM_BIT]) |-> !wr_hit);
  p_rd_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_idx_hit && rd_sum_hit));
endmodule

// File: rtl/msi_index_reg.sv
module msi_index_reg
  import msi_term_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic [VEC_PER_IDX-1:0] set_vec,
  input  logic                   clr_en,
  output logic [VEC_PER_IDX-1:0] pend
);
  logic [VEC_PER_IDX-1:0] kept, added;

  always_comb begin
    kept  = clr_en ? '0 : pend;
    added = set_en ? set_vec : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= kept | added;
  end

  p_set_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((pend & $past(set_vec)) == $past(set_vec)));
  p_clear_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> (pend == '0));
  p_set_survives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_en) |=> (pend == $past(set_vec)));
  p_or_accum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr_en) |=> ((pend & $past(pend)) == $past(pend)));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(pend));
endmodule

// File: rtl/msi_term_group.sv
module msi_term_group
  import msi_term_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_hit_g,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [VEC_PER_IDX-1:0] wr_vec,
  input  logic                   rd_hit_g,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [VEC_PER_IDX-1:0] sel_val,
  output logic [IDX_PER_GRP-1:0] summary,
  output logic                   irq
);
  logic [IDX_PER_GRP-1:0][VEC_PER_IDX-1:0] pend_all;

  for (genvar x = 0; x < IDX_PER_GRP; x++) begin : g_idx
    logic set_x, clr_x;
    assign set_x = wr_hit_g && (wr_idx == IDX_W'(x));
    assign clr_x = rd_hit_g && (rd_idx == IDX_W'(x));
    msi_index_reg u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_x),
      .set_vec(wr_vec),
      .clr_en (clr_x),
      .pend   (pend_all[x])
    );
    assign summary[x] = |pend_all[x];
  end

  assign sel_val = pend_all[rd_idx];
  assign irq     = |summary;

  p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_hit_g));
  p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_hit_g));
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [VEC_PER_IDX-1:0] rd_data,
  output logic [NUM_GRP-1:0]     irq_out
);
  logic                   wr_hit, rd_idx_hit, rd_sum_hit;
  logic [GRP_W-1:0]       wr_grp, rd_grp;
  logic [IDX_W-1:0]       wr_idx, rd_idx;
  logic [VEC_PER_IDX-1:0] wr_vec, rd_next;
  logic [NUM_GRP-1:0]     grp_wr_hit, grp_rd_hit;
  logic [NUM_GRP-1:0][VEC_PER_IDX-1:0] grp_val;
  logic [NUM_GRP-1:0][IDX_PER_GRP-1:0] grp_sum;

  msi_term_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_hit(wr_hit), .wr_grp(wr_grp), .wr_idx(wr_idx), .wr_vec(wr_vec),
    .rd_idx_hit(rd_idx_hit), .rd_sum_hit(rd_sum_hit),
    .rd_grp(rd_grp), .rd_idx(rd_idx)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_wr_hit[g] = wr_hit && (wr_grp == GRP_W'(g));
    assign grp_rd_hit[g] = rd_idx_hit && (rd_grp == GRP_W'(g));
    msi_term_group u_grp (
      .clk(clk), .rst_n(rst_n),
      .wr_hit_g(grp_wr_hit[g]), .wr_idx(wr_idx), .wr_vec(wr_vec),
      .rd_hit_g(grp_rd_hit[g]), .rd_idx(rd_idx),
      .sel_val(grp_val[g]), .summary(grp_sum[g]), .irq(irq_out[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_idx_hit)      rd_next = grp_val[rd_grp];
    else if (rd_sum_hit) rd_next[IDX_PER_GRP-1:0] = grp_sum[rd_grp];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  p_one_group_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_wr_hit));
  p_one_group_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_rd_hit));
  p_sum_read_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sum_hit |-> (grp_rd_hit == '0));
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_idx_hit && !rd_sum_hit) |=> (rd_data == '0));
endmodule

// File: tb/tb_msi_term_bank.sv
module tb_msi_term_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [16][8];

  always #10 clk = ~clk;

  msi_term_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [23:0] ia(input int g, input int x);
    return 24'(g * 524288 + x * 65536);
  endfunction
  function automatic logic [23:0] sa(input int g);
    return 24'(8388608 + g * 65536);
  endfunction
  function automatic bit is_idx(input logic [23:0] a);
    return (int'(a) < 8388608) && (int'(a) % 65536 == 0);
  endfunction
  function automatic bit is_sum(input logic [23:0] a);
    return (int'(a) >= 8388608) && (int'(a) < 9437184) && (int'(a) % 65536 == 0);
  endfunction
  function automatic logic [15:0] summ(input int g);
    logic [15:0] s = '0;
    for (int x = 0; x < 8; x++) s[x] = (mdl[g][x] != 0);
    return s;
  endfunction
  function automatic logic [15:0] irq_exp();
    logic [15:0] v = '0;
    for (int g = 0; g < 16; g++) v[g] = (summ(g) != 0);
    return v;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one cycle from just after a falling edge, checks at the next falling edge.
  task automatic step(input bit wv, input logic [23:0] wa, input logic [31:0] wd,
                      input bit rv, input logic [23:0] ra, input string req);
    logic [15:0] exp_rd = '0;
    int rg, rx, wg, wx;
    wr_valid = wv; wr_addr = wa; wr_data = wd; rd_en = rv; rd_addr = ra;
    if (rv && is_idx(ra)) begin
      rg = int'(ra) / 524288; rx = (int'(ra) / 65536) % 8;
      exp_rd = mdl[rg][rx]; mdl[rg][rx] = '0;
    end else if (rv && is_sum(ra)) begin
      exp_rd = summ((int'(ra) - 8388608) / 65536);
    end
    if (wv && is_idx(wa) && wd < 16) begin
      wg = int'(wa) / 524288; wx = (int'(wa) / 65536) % 8;
      mdl[wg][wx][wd] = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0;
    if (rv) check(req, rd_data, exp_rd);
    check({req, "/R4 irq"}, irq_out, irq_exp());
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d, input string req);
    step(1'b1, a, d, 1'b0, '0, req);
  endtask
  task automatic rd(input logic [23:0] a, input string req);
    step(1'b0, '0, '0, 1'b1, a, req);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    for (int g = 0; g < 16; g++) for (int x = 0; x < 8; x++) mdl[g][x] = '0;
    seed = $urandom(32'h5EED_0042);
    // Reset state (R8)
    wr_valid = 1'b1; wr_addr = ia(2, 1); wr_data = 32'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 rd_data in reset", rd_data, 16'h0);
    check("R8 irq in reset", irq_out, 16'h0);
    wr_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    rd(ia(2, 1), "R8 no write during reset");

    // Basic set, summary, clear-on-read (R1 R2 R3 R4)
    wr(ia(3, 5), 32'd7, "R1 write g3 x5 d7");
    rd(sa(3), "R3 summary g3");
    rd(sa(3), "R3 summary repeat no side effect");
    rd(ia(3, 5), "R1 R2 read g3 x5");
    rd(ia(3, 5), "R2 cleared after read");

    // Boundary group/index/vector (R1)
    wr(ia(15, 7), 32'd15, "R1 g15 x7 d15");
    wr(ia(0, 0), 32'd0, "R1 g0 x0 d0");
    rd(sa(15), "R3 summary g15");
    rd(ia(15, 7), "R1 R2 read g15 x7");
    rd(ia(0, 0), "R1 R2 read g0 x0");

    // Ignored writes (R6 R7)
    wr(ia(4, 2), 32'd16, "R6 data 16");
    wr(ia(4, 2), 32'hFFFF_FFF3, "R6 large data");
    wr(sa(4), 32'd1, "R7 write to summary address");
    wr(ia(4, 2) + 24'd4, 32'd1, "R7 low offset nonzero");
    wr(24'hA00000, 32'd2, "R7 top bit set");
    rd(ia(4, 2), "R6 R7 nothing set");
    rd(sa(4), "R6 R7 summary empty");

    // Same-cycle set and clear (R5)
    wr(ia(1, 2), 32'd3, "R5 prime");
    step(1'b1, ia(1, 2), 32'd9, 1'b1, ia(1, 2), "R5 read shows old contents");
    rd(ia(1, 2), "R5 new bit survived");
    wr(ia(1, 2), 32'd9, "R5 prime same bit");
    step(1'b1, ia(1, 2), 32'd9, 1'b1, ia(1, 2), "R5 same bit read");
    rd(ia(1, 2), "R5 same bit survived");

    // Unmapped reads (R9)
    wr(ia(6, 6), 32'd5, "R9 prime");
    rd(24'h900000, "R9 beyond summary range");
    rd(sa(6) + 24'd2, "R9 summary low offset");
    rd(ia(6, 6) + 24'h100, "R9 index low offset");
    rd(ia(6, 6), "R9 state untouched");

    // Accumulation (R10)
    wr(ia(9, 3), 32'd0, "R10 bit0");
    wr(ia(9, 3), 32'd15, "R10 bit15");
    wr(ia(9, 3), 32'd0, "R10 bit0 again");
    rd(ia(9, 3), "R10 accumulated");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [23:0] wa, ra;
      logic [31:0] wd;
      bit wv, rv;
      k = int'($urandom_range(0, 9));
      wa = ia(int'($urandom_range(0, 15)), int'($urandom_range(0, 7)));
      wd = 32'($urandom_range(0, 15));
      if (k == 0) wd = 32'($urandom_range(16, 40));
      if (k == 1) wa = wa + 24'($urandom_range(1, 65535));
      if (k == 2) wa = sa(int'($urandom_range(0, 15)));
      wv = ($urandom_range(0, 3) != 0);
      k = int'($urandom_range(0, 9));
      if (k < 6) ra = ia(int'($urandom_range(0, 15)), int'($urandom_range(0, 7)));
      else if (k < 9) ra = sa(int'($urandom_range(0, 15)));
      else ra = 24'($urandom_range(9437184, 16777215));
      rv = ($urandom_range(0, 2) == 0);
      step(wv, wa, wd, rv, ra, "R1 R2 R3 R5 R6 R7 R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule